// File: doc/BRIEF.md
# Fault-Only-First Segmented Load Sequencer

This block sequences a contiguous segmented vector load in which a memory fault on the first segment is an exception, but a fault on any later segment is turned into a shorter vector length. After a start command it walks the segments from the starting index `vstart` up to `vl - 1`. Inside each segment it walks every field, emitting one element read request at a time. Each response carries a fault flag. A fault in segment 0 produces a one-cycle trap pulse. A fault in a later segment `i` produces a one-cycle length-update pulse that carries `i`. In both cases the walk stops and a done pulse follows in the next cycle.

Element width is selected by a two-bit code, and the field count is given minus one. Addresses are fully contiguous: every field of every segment occupies consecutive `eew`-sized slots. Register-file writes and the memory itself sit outside the block. The surrounding pipeline supplies responses and consumes the trap, the new length and the done pulse.

Top module: `ffl_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `req_valid`, `trap`, `vl_update` and `done` are low, and `new_vl` is 0.
- R2: The k-th request of an operation (k from 0) is for element e = vstart*NF + k, where NF = nf_m1+1, and its address is base_addr + e*eew bytes modulo 2^AW. This gives segment i, field f at base + i*eew*NF + f*eew, with fields walked before segments.
- R3: `req_valid` is high for exactly one cycle per request. The next request appears only in the cycle after the cycle in which `rsp_valid` was sampled high in the wait state.
- R4: A faulting response for segment 0 raises `trap` for one cycle in the cycle after the response. `vl_update` stays low, no further request is issued, and `done` pulses in the cycle after `trap`.
- R5: A faulting response for segment i ≠ 0 raises `vl_update` for one cycle in the cycle after the response, with `new_vl` = i. `trap` stays low, no further request is issued, and `done` pulses in the cycle after `vl_update`.
- R6: When every request of the operation returns without a fault, `done` pulses for one cycle in the cycle after the last response, and `trap` and `vl_update` stay low.
- R7: A start with vstart ≥ vl issues no request and pulses `done` in the cycle after start.
- R8: A start with `is_store` high is ignored. No request, trap, length update or done follows, and the block stays idle and accepts the next load start.
- R9: `eew_sel` codes 0, 1, 2 and 3 select element widths of 1, 2, 4 and 8 bytes. `nf_m1` values 0 to 7 select 1 to 8 fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| is_store | input | 1 | Direction of the started operation; 1 = store, which is refused |
| base_addr | input | AW | Byte address of segment 0, field 0 |
| eew_sel | input | 2 | Element width code (0:1B, 1:2B, 2:4B, 3:8B) |
| nf_m1 | input | NFW | Number of fields per segment minus one |
| vl | input | VLW | Current vector length in segments |
| vstart | input | VLW | First segment to transfer |
| req_valid | output | 1 | Element read request, one-cycle pulse |
| req_addr | output | AW | Byte address of the requested element |
| rsp_valid | input | 1 | Response for the outstanding request |
| rsp_fault | input | 1 | The responded access faulted |
| trap | output | 1 | Fault in segment 0, one-cycle pulse |
| new_vl | output | VLW | Shortened vector length, valid with `vl_update` |
| vl_update | output | 1 | Vector length shortened, one-cycle pulse |
| done | output | 1 | Operation finished, one-cycle pulse |

## Verification
All outputs are decoded from registered state, so every result is due a fixed number of cycles after the input that caused it. The first request is due one cycle after start, and each later request one cycle after the response. `done` follows the last good response by one cycle, or start by one cycle when the range is empty. `trap` or `vl_update` follows a faulting response by one cycle, and `done` comes one cycle after that. The bench drives inputs and samples outputs on the falling edge. It numbers those edges from the first one after start and records the edge at which each response, flag and done was seen. It then compares those edge numbers against these fixed offsets, together with the request count and each request address computed by bench functions.

// File: rtl/ffl_pkg.sv
package ffl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ISSUE = 3'd1,
      ST_WAIT  = 3'd2,
      ST_TRAP  = 3'd3,
      ST_DONE  = 3'd4
   } ffl_state_e;

   localparam int EEW_SEL_W = 2;

endpackage

// File: rtl/ffl_seq_cnt.sv
// Segment / field position counter of the sequencer.
module ffl_seq_cnt #(
   parameter int VLW = 8,
   parameter int NFW = 3
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic           adv,
   input  logic [VLW-1:0] seg_init,
   input  logic [VLW-1:0] seg_lim,
   input  logic [NFW-1:0] fld_max,
   output logic [VLW-1:0] seg,
   output logic [NFW-1:0] fld,
   output logic           fld_last,
   output logic           seg_last
);
   localparam int SW = VLW + 1;

   logic [VLW-1:0] seg_q;
   logic [VLW-1:0] lim_q;
   logic [NFW-1:0] fld_q;
   logic [NFW-1:0] fmax_q;
   logic [SW-1:0]  seg_inc;

   always_ff @(posedge clk) begin
      if (rst) begin
         seg_q  <= '0;
         lim_q  <= '0;
         fld_q  <= '0;
         fmax_q <= '0;
      end else if (load) begin
         seg_q  <= seg_init;
         lim_q  <= seg_lim;
         fld_q  <= '0;
         fmax_q <= fld_max;
      end else if (adv) begin
         if (fld_q == fmax_q) begin
            fld_q <= '0;
            seg_q <= seg_q + 1'b1;
         end else begin
            fld_q <= fld_q + 1'b1;
         end
      end
   end

   assign seg_inc  = {1'b0, seg_q} + SW'(1);
   assign seg_last = (seg_inc == {1'b0, lim_q});
   assign fld_last = (fld_q == fmax_q);
   assign seg      = seg_q;
   assign fld      = fld_q;

endmodule

// File: rtl/ffl_addr_inc.sv
// Address variant: one start-offset multiply, then a running adder.
module ffl_addr_inc #(
   parameter int AW  = 32,
   parameter int VLW = 8,
   parameter int NFW = 3
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic           adv,
   input  logic [AW-1:0]  base,
   input  logic [1:0]     eew_sel,
   input  logic [NFW-1:0] fld_max,
   input  logic [VLW-1:0] seg_init,
   output logic [AW-1:0]  addr
);
   localparam int FW = NFW + 1;
   localparam int IW = VLW + FW;

   logic [AW-1:0] addr_q;
   logic [1:0]    sel_q;
   logic [IW-1:0] idx_init;
   logic [AW-1:0] step;

   assign idx_init = IW'(seg_init) * IW'(FW'(fld_max) + FW'(1));
   assign step     = AW'(1) << sel_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         sel_q  <= '0;
      end else if (load) begin
         addr_q <= base + (AW'(idx_init) << eew_sel);
         sel_q  <= eew_sel;
      end else if (adv) begin
         addr_q <= addr_q + step;
      end
   end

   assign addr = addr_q;

endmodule

// File: rtl/ffl_addr_mul.sv
// Address variant: recomputed every cycle from the segment/field position.
module ffl_addr_mul #(
   parameter int AW  = 32,
   parameter int VLW = 8,
   parameter int NFW = 3
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic [AW-1:0]  base,
   input  logic [1:0]     eew_sel,
   input  logic [NFW-1:0] fld_max,
   input  logic [VLW-1:0] seg,
   input  logic [NFW-1:0] fld,
   output logic [AW-1:0]  addr
);
   localparam int FW = NFW + 1;
   localparam int IW = VLW + FW;

   logic [AW-1:0]  base_q;
   logic [1:0]     sel_q;
   logic [NFW-1:0] fmax_q;
   logic [IW-1:0]  idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         sel_q  <= '0;
         fmax_q <= '0;
      end else if (load) begin
         base_q <= base;
         sel_q  <= eew_sel;
         fmax_q <= fld_max;
      end
   end

   assign idx  = IW'(seg) * IW'(FW'(fmax_q) + FW'(1)) + IW'(fld);
   assign addr = base_q + (AW'(idx) << sel_q);

endmodule

// File: rtl/ffl_fsm.sv
// Control state machine: issue, wait, fault resolution, completion.
module ffl_fsm
   import ffl_pkg::*;
#(
   parameter int VLW = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic           is_store,
   input  logic [VLW-1:0] vstart,
   input  logic [VLW-1:0] vl,
   input  logic           rsp_valid,
   input  logic           rsp_fault,
   input  logic           fld_last,
   input  logic           seg_last,
   input  logic [VLW-1:0] seg,
   output logic           load,
   output logic           adv,
   output logic           req_valid,
   output logic           trap,
   output logic           vl_update,
   output logic [VLW-1:0] new_vl,
   output logic           done,
   output logic           idle
);
   ffl_state_e     state_q, state_d;
   logic           trim_q;
   logic [VLW-1:0] nvl_q;
   logic           fault_seen;

   assign fault_seen = (state_q == ST_WAIT) && rsp_valid && rsp_fault;

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      adv     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start && !is_store) begin
               load    = 1'b1;
               state_d = (vstart >= vl) ? ST_DONE : ST_ISSUE;
            end
         end
         ST_ISSUE: state_d = ST_WAIT;
         ST_WAIT: begin
            if (rsp_valid) begin
               if (rsp_fault) begin
                  state_d = ST_TRAP;
               end else begin
                  adv     = 1'b1;
                  state_d = (fld_last && seg_last) ? ST_DONE : ST_ISSUE;
               end
            end
         end
         ST_TRAP: state_d = ST_DONE;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         trim_q  <= 1'b0;
         nvl_q   <= '0;
      end else begin
         state_q <= state_d;
         if (fault_seen) begin
            trim_q <= (seg != '0);
            if (seg != '0) nvl_q <= seg;
         end
      end
   end

   assign req_valid = (state_q == ST_ISSUE);
   assign trap      = (state_q == ST_TRAP) && !trim_q;
   assign vl_update = (state_q == ST_TRAP) && trim_q;
   assign done      = (state_q == ST_DONE);
   assign idle      = (state_q == ST_IDLE);
   assign new_vl    = nvl_q;

endmodule

// File: rtl/ffl_ctrl.sv
// Fault-only-first segmented load sequencer, top level.
module ffl_ctrl #(
   parameter int AW        = 32,
   parameter int VLW       = 8,
   parameter int NFW       = 3,
   parameter bit MULT_ADDR = 1'b0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic           is_store,
   input  logic [AW-1:0]  base_addr,
   input  logic [1:0]     eew_sel,
   input  logic [NFW-1:0] nf_m1,
   input  logic [VLW-1:0] vl,
   input  logic [VLW-1:0] vstart,
   output logic           req_valid,
   output logic [AW-1:0]  req_addr,
   input  logic           rsp_valid,
   input  logic           rsp_fault,
   output logic           trap,
   output logic [VLW-1:0] new_vl,
   output logic           vl_update,
   output logic           done
);
   localparam int IW = VLW + NFW + 1;

   if (AW < IW + 3) begin : g_chk_aw
      $error("ffl_ctrl: AW must hold the largest element byte offset");
   end
   if (VLW < 1 || NFW < 1) begin : g_chk_w
      $error("ffl_ctrl: VLW and NFW must be at least 1");
   end

   logic           load, adv, fld_last, seg_last, at_idle;
   logic [VLW-1:0] seg;
   logic [NFW-1:0] fld;

   ffl_fsm #(.VLW(VLW)) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .is_store  (is_store),
      .vstart    (vstart),
      .vl        (vl),
      .rsp_valid (rsp_valid),
      .rsp_fault (rsp_fault),
      .fld_last  (fld_last),
      .seg_last  (seg_last),
      .seg       (seg),
      .load      (load),
      .adv       (adv),
      .req_valid (req_valid),
      .trap      (trap),
      .vl_update (vl_update),
      .new_vl    (new_vl),
      .done      (done),
      .idle      (at_idle)
   );

   ffl_seq_cnt #(.VLW(VLW), .NFW(NFW)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .adv      (adv),
      .seg_init (vstart),
      .seg_lim  (vl),
      .fld_max  (nf_m1),
      .seg      (seg),
      .fld      (fld),
      .fld_last (fld_last),
      .seg_last (seg_last)
   );

   if (MULT_ADDR) begin : g_addr_mul
      ffl_addr_mul #(.AW(AW), .VLW(VLW), .NFW(NFW)) u_addr (
         .clk     (clk),
         .rst     (rst),
         .load    (load),
         .base    (base_addr),
         .eew_sel (eew_sel),
         .fld_max (nf_m1),
         .seg     (seg),
         .fld     (fld),
         .addr    (req_addr)
      );
   end else begin : g_addr_inc
      logic [NFW-1:0] fld_nc;
      assign fld_nc = fld;
      ffl_addr_inc #(.AW(AW), .VLW(VLW), .NFW(NFW)) u_addr (
         .clk      (clk),
         .rst      (rst),
         .load     (load),
         .adv      (adv),
         .base     (base_addr),
         .eew_sel  (eew_sel),
         .fld_max  (nf_m1),
         .seg_init (vstart),
         .addr     (req_addr)
      );
   end

endmodule

// File: rtl/ffl_ctrl_chk.sv
// Temporal checks on the sequencer ports, bound into every ffl_ctrl.
module ffl_ctrl_chk #(
   parameter int VLW = 8
) (
   input logic           clk,
   input logic           rst,
   input logic           start,
   input logic           is_store,
   input logic [VLW-1:0] vl,
   input logic [VLW-1:0] vstart,
   input logic           idle,
   input logic           req_valid,
   input logic           rsp_valid,
   input logic           trap,
   input logic           vl_update,
   input logic [VLW-1:0] new_vl,
   input logic           done
);
   AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!req_valid && !trap && !vl_update && !done)); // R1
   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) req_valid |=> !req_valid); // R3
   AST_REQ_NO_EARLY_RSP: assert property (@(posedge clk) disable iff (rst) (req_valid && !rsp_valid) |=> !req_valid); // R3
   AST_TRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) trap |-> !vl_update && !req_valid); // R4
   AST_TRAP_THEN_DONE: assert property (@(posedge clk) disable iff (rst) trap |=> done && !req_valid); // R4
   AST_TRIM_THEN_DONE: assert property (@(posedge clk) disable iff (rst) vl_update |=> done && !req_valid); // R5
   AST_TRIM_NONZERO: assert property (@(posedge clk) disable iff (rst) vl_update |-> new_vl != '0); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done && !req_valid); // R6
   AST_EMPTY_RANGE: assert property (@(posedge clk) disable iff (rst) (idle && start && !is_store && (vstart >= vl)) |=> done && !req_valid); // R7
   AST_STORE_REFUSED: assert property (@(posedge clk) disable iff (rst) (idle && start && is_store) |=> !req_valid && !done && idle); // R8
endmodule

bind ffl_ctrl ffl_ctrl_chk #(.VLW(VLW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .is_store  (is_store),
   .vl        (vl),
   .vstart    (vstart),
   .idle      (at_idle),
   .req_valid (req_valid),
   .rsp_valid (rsp_valid),
   .trap      (trap),
   .vl_update (vl_update),
   .new_vl    (new_vl),
   .done      (done)
);

// File: tb/ffl_ctrl_tb.sv
module ffl_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW  = 32;
   localparam int VLW = 8;
   localparam int NFW = 3;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           start = 1'b0;
   logic           is_store = 1'b0;
   logic [AW-1:0]  base_addr = '0;
   logic [1:0]     eew_sel = '0;
   logic [NFW-1:0] nf_m1 = '0;
   logic [VLW-1:0] vl = '0;
   logic [VLW-1:0] vstart = '0;
   logic           req_valid;
   logic [AW-1:0]  req_addr;
   logic           rsp_valid = 1'b0;
   logic           rsp_fault = 1'b0;
   logic           trap;
   logic [VLW-1:0] new_vl;
   logic           vl_update;
   logic           done;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ffl_ctrl #(.AW(AW), .VLW(VLW), .NFW(NFW)) u_dut (
      .clk(clk), .rst(rst), .start(start), .is_store(is_store),
      .base_addr(base_addr), .eew_sel(eew_sel), .nf_m1(nf_m1),
      .vl(vl), .vstart(vstart), .req_valid(req_valid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .trap(trap),
      .new_vl(new_vl), .vl_update(vl_update), .done(done)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Element byte address (R2, R9)
   function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int sel, input int elem);
      return b + AW'(longint'(elem) << sel);
   endfunction

   function automatic int exp_total(input int nf, input int vlv, input int vst);
      return (vst < vlv) ? (vlv - vst) * nf : 0;
   endfunction

   task automatic run_op(input logic [AW-1:0] b, input int sel, input int nfm1,
                         input int vlv, input int vst, input int fk);
      int nf, total, e_reqs, e_trap, e_trim, e_nvl, fseg;
      int ridx, dly, cyc, done_at, flag_at, last_rsp, trap_cnt, upd_cnt, seen_nvl;
      bit pending;
      nf = nfm1 + 1;
      total = exp_total(nf, vlv, vst);
      e_trap = 0; e_trim = 0; e_nvl = 0;
      if (fk >= 0 && fk < total) begin
         e_reqs = fk + 1;
         fseg = vst + fk / nf;
         if (fseg == 0) e_trap = 1;
         else begin e_trim = 1; e_nvl = fseg; end
      end else begin
         e_reqs = total;
      end
      @(negedge clk);
      start = 1'b1; is_store = 1'b0; base_addr = b;
      eew_sel = 2'(sel); nf_m1 = NFW'(nfm1); vl = VLW'(vlv); vstart = VLW'(vst);
      @(negedge clk);
      start = 1'b0;
      ridx = 0; dly = 0; pending = 1'b0; cyc = 0;
      done_at = -1; flag_at = -1; last_rsp = -1; trap_cnt = 0; upd_cnt = 0; seen_nvl = 0;
      while (cyc < 4000) begin
         rsp_valid = 1'b0; rsp_fault = 1'b0;
         if (trap) begin trap_cnt++; flag_at = cyc; end
         if (vl_update) begin upd_cnt++; flag_at = cyc; seen_nvl = int'(new_vl); end
         if (done) begin done_at = cyc; break; end
         if (pending) begin
            if (dly == 0) begin
               rsp_valid = 1'b1;
               rsp_fault = ((ridx - 1) == fk);
               last_rsp = cyc;
               pending = 1'b0;
            end else dly--;
         end
         if (req_valid) begin
            check(req_addr == exp_addr(b, sel, vst * nf + ridx), "R2 R9 request address",
                  longint'(req_addr), longint'(exp_addr(b, sel, vst * nf + ridx)));
            check(!pending, "R3 request while one outstanding", 1, 0);
            ridx++;
            pending = 1'b1;
            dly = int'($urandom % 3);
         end
         @(negedge clk);
         cyc++;
      end
      check(done_at >= 0, "R6 done seen", done_at, 0);
      check(ridx == e_reqs, "R3 request count", ridx, e_reqs);
      check(trap_cnt == e_trap, "R4 trap count", trap_cnt, e_trap);
      check(upd_cnt == e_trim, "R5 vl_update count", upd_cnt, e_trim);
      if (e_trim == 1) check(seen_nvl == e_nvl, "R5 new_vl value", seen_nvl, e_nvl);
      if (total == 0) begin
         check(done_at == 0, "R7 done one cycle after start", done_at, 0);
      end else if (e_trap + e_trim > 0) begin
         check(flag_at == last_rsp + 1, "R4 R5 flag one cycle after fault", flag_at, last_rsp + 1);
         check(done_at == flag_at + 1, "R4 R5 done one cycle after flag", done_at, flag_at + 1);
      end else begin
         check(done_at == last_rsp + 1, "R6 done one cycle after last response", done_at, last_rsp + 1);
      end
      @(negedge clk);
      rsp_valid = 1'b0; rsp_fault = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      int unsigned seed_sink;
      seed_sink = $urandom(32'h5eed_0f1f);
      repeat (3) @(negedge clk);
      check(!req_valid && !trap && !vl_update && !done, "R1 outputs quiet in reset",
            {req_valid, trap, vl_update, done}, 0);
      check(new_vl == '0, "R1 new_vl in reset", new_vl, 0);
      rst = 1'b0;
      @(negedge clk);
      check(!req_valid && !trap && !vl_update && !done, "R1 outputs quiet after reset",
            {req_valid, trap, vl_update, done}, 0);

      // R8: store start is refused
      start = 1'b1; is_store = 1'b1; vl = 8'd4; vstart = 8'd0; nf_m1 = 3'd1;
      @(negedge clk);
      start = 1'b0; is_store = 1'b0;
      for (int i = 0; i < 4; i++) begin
         check(!req_valid && !done && !trap && !vl_update, "R8 store start ignored",
               {req_valid, done, trap, vl_update}, 0);
         @(negedge clk);
      end
      run_op(32'h0000_1000, 2, 1, 3, 0, -1);            // R8 load still accepted afterwards

      // Directed corners
      run_op(32'h0000_2000, 0, 2, 4, 0, 1);             // R4 fault inside segment 0
      run_op(32'h0000_2000, 1, 1, 6, 0, 7);             // R5 fault in segment 3
      run_op(32'h0000_3000, 3, 0, 5, 2, 0);             // R5 first element at vstart=2 faults
      run_op(32'h0000_4000, 2, 3, 5, 5, -1);            // R7 vstart == vl
      run_op(32'h0000_4000, 2, 3, 2, 7, -1);            // R7 vstart > vl
      run_op(32'h0000_4000, 0, 0, 0, 0, -1);            // R7 vl == 0
      run_op(32'h0000_5000, 3, 7, 3, 0, -1);            // R9 widest element, eight fields
      run_op(32'hFFFF_FFF0, 2, 2, 4, 1, -1);            // R2 address wraps
      run_op(32'h0000_6000, 0, 0, 1, 0, 0);             // R4 single element faults
      run_op(32'h0000_6000, 1, 4, 4, 0, 19);            // R5 last element of last segment

      // Constrained random mix
      for (int n = 0; n < 60; n++) begin
         int sel, nfm1, vlv, vst, tot, fk;
         sel  = int'($urandom % 4);
         nfm1 = int'($urandom % 8);
         vlv  = int'($urandom % 12);
         vst  = int'($urandom % (vlv + 2));
         tot  = exp_total(nfm1 + 1, vlv, vst);
         fk   = (tot == 0 || ($urandom % 3) == 0) ? -1 : int'($urandom % (tot + 1));
         run_op($urandom, sel, nfm1, vlv, vst, fk);
      end
      finish_run();
   end
endmodule